// File: doc/BRIEF.md
# Bus Event Qualifier and Trace Buffer

This block watches a parallel data bus and records selected samples of it into an on-chip trace memory. A sampling strobe is formed from a programmable logic combination of three external clock/strobe pins and the test clock. Every pin is synchronised into the system clock domain, and the rising edge of the selected combination yields a one-cycle strobe, so no derived clock exists. At each strobe the sampled bus word is compared against two stored patterns under a shared don't-care mask. One of eight storage protocols then decides whether that word is written to the trace memory.

An event output goes high on the first qualified match and stays high until the unit is re-armed. An external agent can use it to hold or halt the processor that drives the bus. An event input lets a neighbouring unit inject a match, so several units can be chained into one wider comparison. Software programs the unit through a small register-write port and reads the trace back through a registered read port. The current write pointer and a wrap flag are visible at the ports.

Top module: `bus_event_trace`

## Requirements
- R1: After reset the write pointer is 0, the wrap flag is 0, the event output is 0 and no sample is stored until the unit is armed.
- R2: Register writes use address 0 for pattern A, 1 for pattern B, 2 for the mask and 3 for control. The control fields are protocol in bits [2:0], strobe select in bits [7:3] and arm in bit 8. Every control write re-arms the unit: the pointer and the wrap flag go to 0, the event output goes to 0 and the protocol returns to its waiting state. While arm is 0, strobes store nothing.
- R3: Let the source vector be s = {tck, ext[2], ext[1], ext[0]}. Let the select value be split into k = sel[4:2] and i = sel[1:0], with a = s[i] and b = s[(i+1) mod 4]. The combination is selected by k: 0 gives a, 1 gives ~a, 2 gives a&b, 3 gives a|b, 4 gives a^b, 5 gives a&~b, 6 gives ~(a&b) and 7 gives ~(a|b).
- R4: Each rising edge of the selected combination produces exactly one sample, however long the level is held.
- R5: A mask bit of 1 makes that bus bit irrelevant to both compares. When the event input is high, it counts as a match on pattern A.
- R6: Protocol 0 never stores, protocol 1 stores every sample, and protocol 2 stores each sample that matches A.
- R7: Protocol 3 (do-while) waits for an A match. It stores that sample and each following sample that matches A. At the first sample that does not match A it stops for good.
- R8: Protocol 4 (start/stop) waits for an A match, then stores every sample from that one onward. It stops for good at a B match, and that B sample is not stored.
- R9: Protocol 5 (start/pause/resume) starts storing at an A match and pauses at a B match, without storing the B sample. It resumes at the next A match, storing that sample.
- R10: Protocol 6 (start-only) stores every sample from the first A match onward. Protocol 7 (stop-only) stores every sample until the first B match, then stops for good without storing the B sample.
- R11: Each stored sample goes to the address given by the write pointer, and the pointer then advances by one, wrapping from DEPTH-1 to 0. The wrap flag sets on the first wrap and stays set until re-arm.
- R12: The read port returns the word at the read address one clock after that address is presented.
- R13: The event output sets at a sample that matches A or B while armed, in every protocol. It holds until the next control write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk_i | input | 3 | External clock/strobe pins |
| tck_i | input | 1 | Test clock used as a fourth strobe source |
| bus_i | input | DATA_W | Monitored bus |
| eq_in_i | input | 1 | Cascaded event input, counts as an A match |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | DATA_W | Register write data |
| rd_addr_i | input | AW | Trace read address |
| rd_data_o | output | DATA_W | Trace read data, one cycle latency |
| wr_ptr_o | output | AW | Next trace write address |
| full_o | output | 1 | Trace has wrapped |
| eq_out_o | output | 1 | Sticky event output |

## Verification
The hardest conditions to reach are the paused and finished protocol states and the strobe combinations whose idle level is already high. In those combinations a sample comes from the falling edge of a pin, not the rising one. The bench reaches every select code by re-arming with the sources at rest and then raising each of the fifteen non-zero source patterns in turn. It counts the stored samples against the number of rising edges of the combination. For the protocols, one fixed bus sequence interleaves A and B matches under a nibble mask, and the expected trace for each protocol follows from a small state model in the bench. The trace memory is shrunk to 16 words, so wrap and mask sweeps finish in a few hundred strobes.

// File: rtl/bet_pkg.sv
package bet_pkg;

  localparam int SRC_W    = 4;
  localparam int CTL_W    = 9;
  localparam int PROTO_LSB = 0;
  localparam int SEL_LSB  = 3;
  localparam int ARM_BIT  = 8;

  localparam logic [1:0] REG_PAT_A = 2'd0;
  localparam logic [1:0] REG_PAT_B = 2'd1;
  localparam logic [1:0] REG_MASK  = 2'd2;
  localparam logic [1:0] REG_CTL   = 2'd3;

  typedef enum logic [2:0] {
    P_OFF        = 3'd0,
    P_ALWAYS     = 3'd1,
    P_ON_MATCH   = 3'd2,
    P_DO_WHILE   = 3'd3,
    P_START_STOP = 3'd4,
    P_PAUSE      = 3'd5,
    P_START_ONLY = 3'd6,
    P_STOP_ONLY  = 3'd7
  } proto_e;

  typedef enum logic [1:0] {
    S_WAIT   = 2'd0,
    S_ACTIVE = 2'd1,
    S_PAUSED = 2'd2,
    S_DONE   = 2'd3
  } pstate_e;

  // Combination of the synchronised strobe sources chosen by a 5-bit select.
  function automatic logic pick_combo(input logic [4:0] sel, input logic [SRC_W-1:0] s);
    logic a;
    logic b;
    logic [1:0] j;
    j = sel[1:0] + 2'd1;
    a = s[sel[1:0]];
    b = s[j];
    case (sel[4:2])
      3'd0:    return a;
      3'd1:    return ~a;
      3'd2:    return a & b;
      3'd3:    return a | b;
      3'd4:    return a ^ b;
      3'd5:    return a & ~b;
      3'd6:    return ~(a & b);
      default: return ~(a | b);
    endcase
  endfunction

endpackage

// File: rtl/bet_strobe_gen.sv
module bet_strobe_gen
  import bet_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] src_i,
  input  logic [4:0]       sel_i,
  output logic             stb_o
);

  logic [SRC_W-1:0] chain_q [SYNC_STAGES];
  logic             level;
  logic             level_q;
  logic             stb_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= '0;
        else     chain_q[0] <= src_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain_q[g] <= '0;
        else     chain_q[g] <= chain_q[g-1];
      end
    end
  end

  always_comb level = pick_combo(sel_i, chain_q[SYNC_STAGES-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      level_q <= level;
      stb_q   <= level & ~level_q;
    end
  end

  assign stb_o = stb_q;

  // R4: a strobe never lasts more than one cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    stb_q |=> !stb_q);

endmodule

// File: rtl/bet_match.sv
module bet_match #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] bus_i,
  input  logic [DATA_W-1:0] pat_a_i,
  input  logic [DATA_W-1:0] pat_b_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic              casc_i,
  output logic              hit_a_o,
  output logic              hit_b_o
);

  logic [DATA_W-1:0] diff_a;
  logic [DATA_W-1:0] diff_b;

  always_comb begin
    diff_a  = (bus_i ^ pat_a_i) & ~mask_i;
    diff_b  = (bus_i ^ pat_b_i) & ~mask_i;
    hit_a_o = (diff_a == '0) | casc_i;
    hit_b_o = (diff_b == '0);
  end

endmodule

// File: rtl/bet_protocol.sv
module bet_protocol
  import bet_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   restart_i,
  input  logic   stb_i,
  input  proto_e proto_i,
  input  logic   hit_a_i,
  input  logic   hit_b_i,
  output logic   store_o
);

  pstate_e st_q;
  pstate_e st_d;

  always_comb begin
    st_d    = st_q;
    store_o = 1'b0;
    if (stb_i) begin
      case (proto_i)
        P_OFF:      ;
        P_ALWAYS:   store_o = 1'b1;
        P_ON_MATCH: store_o = hit_a_i;
        P_DO_WHILE: begin
          if (st_q == S_WAIT) begin
            if (hit_a_i) begin
              store_o = 1'b1;
              st_d    = S_ACTIVE;
            end
          end else if (st_q == S_ACTIVE) begin
            if (hit_a_i) store_o = 1'b1;
            else         st_d    = S_DONE;
          end
        end
        P_START_STOP: begin
          if (st_q == S_WAIT) begin
            if (hit_a_i) begin
              store_o = 1'b1;
              st_d    = S_ACTIVE;
            end
          end else if (st_q == S_ACTIVE) begin
            if (hit_b_i) st_d    = S_DONE;
            else         store_o = 1'b1;
          end
        end
        P_PAUSE: begin
          if (st_q == S_WAIT || st_q == S_PAUSED) begin
            if (hit_a_i) begin
              store_o = 1'b1;
              st_d    = S_ACTIVE;
            end
          end else if (st_q == S_ACTIVE) begin
            if (hit_b_i) st_d    = S_PAUSED;
            else         store_o = 1'b1;
          end
        end
        P_START_ONLY: begin
          if (st_q == S_WAIT) begin
            if (hit_a_i) begin
              store_o = 1'b1;
              st_d    = S_ACTIVE;
            end
          end else begin
            store_o = 1'b1;
          end
        end
        default: begin
          if (st_q == S_WAIT) begin
            if (hit_b_i) st_d    = S_DONE;
            else         store_o = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || restart_i) st_q <= S_WAIT;
    else                  st_q <= st_d;
  end

  // R7 R8 R10: a finished protocol stays finished until re-armed
  a_r8_done_holds: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_DONE && !restart_i) |=> st_q == S_DONE);

  // R6: the off protocol never writes the trace
  a_r6_off_silent: assert property (@(posedge clk) disable iff (rst)
    (proto_i == P_OFF) |-> !store_o);

  // R9: only the pause protocol can sit in the paused state
  a_r9_pause_owner: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_PAUSED) |-> proto_i == P_PAUSE);

  // R2: no write without a strobe
  a_r2_no_stb_no_store: assert property (@(posedge clk) disable iff (rst)
    !stb_i |-> !store_o);

endmodule

// File: rtl/bet_trace_ram.sv
module bet_trace_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [AW-1:0]     wr_ptr_o,
  output logic              full_o
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr_q;
  logic              full_q;
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we_i && !restart_i) mem[wr_ptr_q] <= din_i;
    rd_q <= mem[rd_addr_i];
  end

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      wr_ptr_q <= '0;
      full_q   <= 1'b0;
    end else if (we_i) begin
      wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (wr_ptr_q == LAST) full_q <= 1'b1;
    end
  end

  assign rd_data_o = rd_q;
  assign wr_ptr_o  = wr_ptr_q;
  assign full_o    = full_q;

  // R11: the pointer moves only on a write
  a_r11_ptr_idle: assert property (@(posedge clk) disable iff (rst)
    (!we_i && !restart_i) |=> $stable(wr_ptr_q));

  // R11: the wrap flag is sticky
  a_r11_full_sticky: assert property (@(posedge clk) disable iff (rst)
    (full_q && !restart_i) |=> full_q);

  // R11: the flag rises exactly as the pointer returns to zero
  a_r11_full_at_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(full_q) |-> wr_ptr_q == '0);

endmodule

// File: rtl/bus_event_trace.sv
module bus_event_trace
  import bet_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int DEPTH       = 1024,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        ext_clk_i,
  input  logic              tck_i,
  input  logic [DATA_W-1:0] bus_i,
  input  logic              eq_in_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [AW-1:0]     wr_ptr_o,
  output logic              full_o,
  output logic              eq_out_o
);

  logic [DATA_W-1:0]      pat_a_q;
  logic [DATA_W-1:0]      pat_b_q;
  logic [DATA_W-1:0]      mask_q;
  logic [CTL_W-1:0]       ctl_q;
  logic                   restart;
  proto_e                 proto;
  logic [4:0]             sel;
  logic                   armed;
  logic [DATA_W-1:0]      bus_q;
  logic [SYNC_STAGES-1:0] casc_q;
  logic                   stb_raw;
  logic                   stb_ok;
  logic                   hit_a;
  logic                   hit_b;
  logic                   store;
  logic                   eq_q;

  assign restart = cfg_we_i && (cfg_addr_i == REG_CTL);

  always_ff @(posedge clk) begin
    if (rst) begin
      pat_a_q <= '0;
      pat_b_q <= '0;
      mask_q  <= '0;
      ctl_q   <= '0;
    end else if (cfg_we_i) begin
      case (cfg_addr_i)
        REG_PAT_A: pat_a_q <= cfg_wdata_i;
        REG_PAT_B: pat_b_q <= cfg_wdata_i;
        REG_MASK:  mask_q  <= cfg_wdata_i;
        default:   ctl_q   <= cfg_wdata_i[CTL_W-1:0];
      endcase
    end
  end

  always_comb begin
    proto = proto_e'(ctl_q[PROTO_LSB +: 3]);
    sel   = ctl_q[SEL_LSB +: 5];
    armed = ctl_q[ARM_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_q  <= '0;
      casc_q <= '0;
    end else begin
      bus_q  <= bus_i;
      casc_q <= {casc_q[SYNC_STAGES-2:0], eq_in_i};
    end
  end

  bet_strobe_gen #(
    .SYNC_STAGES(SYNC_STAGES)
  ) strobe_i (
    .clk   (clk),
    .rst   (rst),
    .src_i ({tck_i, ext_clk_i}),
    .sel_i (sel),
    .stb_o (stb_raw)
  );

  assign stb_ok = stb_raw & armed & ~restart;

  bet_match #(
    .DATA_W(DATA_W)
  ) match_i (
    .bus_i   (bus_q),
    .pat_a_i (pat_a_q),
    .pat_b_i (pat_b_q),
    .mask_i  (mask_q),
    .casc_i  (casc_q[SYNC_STAGES-1]),
    .hit_a_o (hit_a),
    .hit_b_o (hit_b)
  );

  bet_protocol proto_i (
    .clk       (clk),
    .rst       (rst),
    .restart_i (restart),
    .stb_i     (stb_ok),
    .proto_i   (proto),
    .hit_a_i   (hit_a),
    .hit_b_i   (hit_b),
    .store_o   (store)
  );

  bet_trace_ram #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH)
  ) ram_i (
    .clk       (clk),
    .rst       (rst),
    .restart_i (restart),
    .we_i      (store),
    .din_i     (bus_q),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .wr_ptr_o  (wr_ptr_o),
    .full_o    (full_o)
  );

  always_ff @(posedge clk) begin
    if (rst || restart)                eq_q <= 1'b0;
    else if (stb_ok && (hit_a || hit_b)) eq_q <= 1'b1;
  end

  assign eq_out_o = eq_q;

  // R13: the event output stays high until re-armed
  a_r13_eq_sticky: assert property (@(posedge clk) disable iff (rst)
    (eq_q && !restart) |=> eq_q);

  // R2: a control write clears the event output
  a_r2_rearm_clears: assert property (@(posedge clk) disable iff (rst)
    restart |=> !eq_q);

  // R2: nothing is stored while disarmed
  a_r2_disarmed_quiet: assert property (@(posedge clk) disable iff (rst)
    (!armed && !restart) |=> $stable(wr_ptr_o));

endmodule

// File: tb/bus_event_trace_tb.sv
`timescale 1ns/1ps
module bus_event_trace_tb_top;

  localparam int W     = 16;
  localparam int DEPTH = 16;
  localparam int AW    = 4;
  localparam logic [15:0] CA = 16'h1234;
  localparam logic [15:0] CB = 16'hABCD;
  localparam logic [15:0] MK = 16'h000F;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    ext_clk = '0;
  logic          tck = 1'b0;
  logic [W-1:0]  bus = '0;
  logic          eq_in = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [W-1:0]  cfg_wdata = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [W-1:0]  rd_data;
  logic [AW-1:0] wr_ptr;
  logic          full;
  logic          eq_out;

  int checks = 0;
  int errors = 0;

  logic [15:0] seq [12] = '{16'h0001, 16'h1230, 16'h5555, 16'hABC0, 16'h1239, 16'h7777,
                            16'hABCF, 16'h1111, 16'h123F, 16'h2222, 16'h3333, 16'hABCD};

  always #2.5 clk = ~clk;

  bus_event_trace #(.DATA_W(W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .ext_clk_i(ext_clk), .tck_i(tck), .bus_i(bus),
    .eq_in_i(eq_in), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .wr_ptr_o(wr_ptr), .full_o(full),
    .eq_out_o(eq_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_ctl(input int p, input logic [4:0] s, input bit arm);
    cfg(2'd3, {7'd0, arm, s, p[2:0]});
  endtask

  task automatic start(input int p, input logic [4:0] s);
    set_ctl(p, s, 1'b0);
    repeat (4) @(negedge clk);
    set_ctl(p, s, 1'b1);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(input logic [15:0] v, input bit casc);
    @(negedge clk);
    bus = v; eq_in = casc; ext_clk[0] = 1'b1;
    repeat (6) @(negedge clk);
    ext_clk[0] = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic readmem(input int a, output logic [15:0] v);
    @(negedge clk);
    rd_addr = a[AW-1:0];
    @(negedge clk);
    v = rd_data;
  endtask

  function automatic bit combo(input logic [4:0] s, input logic [3:0] v);
    bit a, b;
    a = v[s[1:0]];
    b = v[(s[1:0] + 1) % 4];
    case (s[4:2])
      3'd0: return a;
      3'd1: return !a;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return a & !b;
      3'd6: return !(a & b);
      default: return !(a | b);
    endcase
  endfunction

  task automatic run_proto(input int p, input string req);
    logic [15:0] expm [DEPTH];
    logic [15:0] v;
    logic [15:0] got;
    int n, ms;
    bit a, b, st, eqx;
    n = 0; ms = 0; eqx = 0;
    start(p, 5'd0);
    for (int i = 0; i < 12; i++) begin
      v = seq[i];
      a = ((v ^ CA) & ~MK) == 16'h0;
      b = ((v ^ CB) & ~MK) == 16'h0;
      st = 0;
      case (p)
        0: ;
        1: st = 1;
        2: st = a;
        3: if (ms == 0) begin if (a) begin st = 1; ms = 1; end end
           else if (ms == 1) begin if (a) st = 1; else ms = 3; end
        4: if (ms == 0) begin if (a) begin st = 1; ms = 1; end end
           else if (ms == 1) begin if (b) ms = 3; else st = 1; end
        5: if (ms == 0 || ms == 2) begin if (a) begin st = 1; ms = 1; end end
           else if (b) ms = 2; else st = 1;
        6: if (ms == 0) begin if (a) begin st = 1; ms = 1; end end
           else st = 1;
        default: if (ms == 0) begin if (b) ms = 3; else st = 1; end
      endcase
      if (st) begin expm[n % DEPTH] = v; n++; end
      eqx |= (a | b);
      pulse(v, 1'b0);
    end
    chk(wr_ptr == AW'(n % DEPTH), req, wr_ptr, n);
    chk(eq_out == eqx, "R13 event after protocol run", eq_out, eqx);
    for (int j = 0; j < n; j++) begin
      readmem(j, got);
      chk(got == expm[j], req, got, expm[j]);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [15:0] got;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(wr_ptr == '0, "R1 pointer", wr_ptr, 0);
    chk(full == 1'b0, "R1 full", full, 0);
    chk(eq_out == 1'b0, "R1 event", eq_out, 0);
    pulse(16'h1234, 1'b0);
    chk(wr_ptr == '0, "R1 unarmed store", wr_ptr, 0);

    // R3 R4 strobe select sweep
    for (int s = 0; s < 32; s++) begin
      int expc;
      bit f0;
      f0 = combo(s[4:0], 4'd0);
      expc = 0;
      start(1, s[4:0]);
      for (int v = 1; v < 16; v++) begin
        logic [3:0] vv;
        vv = v[3:0];
        if (combo(s[4:0], vv) != f0) expc++;
        @(negedge clk);
        ext_clk = vv[2:0]; tck = vv[3];
        repeat (6) @(negedge clk);
        ext_clk = '0; tck = 1'b0;
        repeat (6) @(negedge clk);
      end
      chk(wr_ptr == AW'(expc), "R3 R4 strobe combination", {s[15:0], 12'h0, wr_ptr}, expc);
    end

    cfg(2'd0, CA);
    cfg(2'd1, CB);
    cfg(2'd2, MK);

    // R6 R7 R8 R9 R10 protocols
    run_proto(0, "R6 protocol off");
    run_proto(1, "R6 protocol always");
    run_proto(2, "R6 protocol on-match");
    run_proto(3, "R7 do-while");
    run_proto(4, "R8 start/stop");
    run_proto(5, "R9 start/pause/resume");
    run_proto(6, "R10 start-only");
    run_proto(7, "R10 stop-only");

    // R5 mask bit sweep
    start(2, 5'd0);
    for (int i = 0; i < 16; i++) begin
      cfg(2'd2, 16'(1 << i));
      pulse(CA ^ 16'(1 << i), 1'b0);
      chk(wr_ptr == AW'((i + 1) % DEPTH), "R5 masked bit ignored", wr_ptr, (i + 1) % DEPTH);
      cfg(2'd2, 16'h0);
      pulse(CA ^ 16'(1 << i), 1'b0);
      chk(wr_ptr == AW'((i + 1) % DEPTH), "R5 unmasked bit compared", wr_ptr, (i + 1) % DEPTH);
    end
    chk(full == 1'b1, "R11 full after mask sweep wrap", full, 1);

    // R11 wrap and full
    start(1, 5'd0);
    chk(full == 1'b0, "R2 re-arm clears full", full, 0);
    for (int k = 0; k < 20; k++) pulse(16'h0100 + 16'(k), 1'b0);
    chk(wr_ptr == AW'(4), "R11 pointer after wrap", wr_ptr, 4);
    chk(full == 1'b1, "R11 full flag", full, 1);
    for (int j = 0; j < DEPTH; j++) begin
      logic [15:0] e;
      e = (j < 4) ? 16'h0100 + 16'(16 + j) : 16'h0100 + 16'(j);
      readmem(j, got);
      chk(got == e, "R11 R12 wrapped trace", got, e);
    end

    // R5 R13 cascade input
    cfg(2'd2, 16'h0);
    start(2, 5'd0);
    pulse(16'h0F0F, 1'b0);
    chk(wr_ptr == '0, "R5 no match no store", wr_ptr, 0);
    chk(eq_out == 1'b0, "R13 no match no event", eq_out, 0);
    pulse(16'h0F0F, 1'b1);
    chk(wr_ptr == AW'(1), "R5 cascade counts as A", wr_ptr, 1);
    chk(eq_out == 1'b1, "R13 event from cascade", eq_out, 1);
    readmem(0, got);
    chk(got == 16'h0F0F, "R12 cascade sample", got, 16'h0F0F);
    pulse(16'h0F0F, 1'b0);
    chk(eq_out == 1'b1, "R13 event held", eq_out, 1);
    set_ctl(2, 5'd0, 1'b1);
    @(negedge clk);
    chk(eq_out == 1'b0, "R2 R13 control write clears event", eq_out, 0);
    chk(wr_ptr == '0, "R2 control write clears pointer", wr_ptr, 0);

    // R2 disarmed ignores strobes
    set_ctl(1, 5'd0, 1'b0);
    for (int k = 0; k < 3; k++) pulse(CA, 1'b1);
    chk(wr_ptr == '0, "R2 disarmed pointer", wr_ptr, 0);
    chk(eq_out == 1'b0, "R2 disarmed event", eq_out, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule